// File: doc/BRIEF.md
# Adaptive Measurement Gate Controller

This block times the measurement gate of a counter that runs with an automatically chosen gate time. A decade pulse arrives each time the input count passes another power of ten. The first decade pulse after the rearm line is released opens the gate and starts a minimum-hold timer of `INH_CYC` clock cycles. Decade pulses that arrive while the timer runs are dropped. The first decade pulse at or after the timer's expiry closes the gate. Because decade pulses are spaced by factors of ten, the resulting gate lasts between one and about ten times the minimum hold.

When the gate closes, the block raises a one-cycle completion strobe and presents the gate's open time in clock cycles. After a completed measurement the controller stays idle until the rearm line is pulsed. Holding the rearm line high at any moment clears the gate and aborts a measurement in progress. The mode-select input qualifies only the opening pulse.

The result is a plain qualified output, with no back-pressure. `meas_done` marks the one cycle in which a new `gate_len` is first valid. `gate_len` then holds its value until the next gate opens, so a consumer may read it at any later time before it starts another measurement.

Top module: `agate_ctrl`

## Requirements
- R1: After reset, `gate_open` and `meas_done` are 0 and `gate_len` is 0.
- R2: While `rearm` is sampled high, decade pulses have no effect. If the gate was open, `gate_open` is 0 from that edge onward and `meas_done` stays 0.
- R3: With `rearm` low, `auto_en` high and the controller ready, a decade pulse sampled at edge E0 makes `gate_open` 1 from E0. With `auto_en` low, the same pulse leaves `gate_open` at 0.
- R4: A decade pulse sampled at edge E0+k with k < `INH_CYC` leaves the gate open and `meas_done` at 0.
- R5: The first decade pulse sampled at edge E0+k with k >= `INH_CYC` makes `gate_open` 0 from that edge.
- R6: `meas_done` is 1 for exactly the one cycle after the closing edge.
- R7: `gate_len` equals the number of edges from the opening edge to the closing edge (k). It holds that value until the next opening.
- R8: `gate_len` saturates at 2^`LEN_W`-1 and does not wrap.
- R9: After a completed measurement, decade pulses do not reopen the gate until `rearm` has been sampled high and then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rearm | input | 1 | Clears the gate and returns the controller to ready while high |
| auto_en | input | 1 | Automatic gate mode select; qualifies the opening pulse |
| decade_pulse | input | 1 | One-cycle pulse for each power-of-ten count overflow |
| gate_open | output | 1 | Measurement gate is open |
| meas_done | output | 1 | One-cycle strobe: gate just closed and `gate_len` is new |
| gate_len | output | LEN_W | Open duration of the last gate in clock cycles |

## Verification
Every result is due in the cycle that follows the sampling edge of its cause. `gate_open` changes right after the edge that samples the opening pulse, the closing pulse or rearm. `meas_done` and the new `gate_len` appear after the closing edge, and `meas_done` drops one edge later. The bench drives each pulse on a falling edge so that exactly one rising edge samples it. It reads the outputs at the next falling edge, and it places pulses at counted offsets from the opening edge, including `INH_CYC`-1 and `INH_CYC`.

// File: rtl/agate_pkg.sv
package agate_pkg;
  typedef enum logic [1:0] {
    ST_READY  = 2'd0,
    ST_HOLD   = 2'd1,
    ST_ARMED  = 2'd2,
    ST_SPENT  = 2'd3
  } agate_st_t;
endpackage

// File: rtl/agate_oneshot.sv
module agate_oneshot #(
  parameter int INH_CYC = 110
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic run,
  output logic expired
);
  localparam int CW = (INH_CYC > 1) ? $clog2(INH_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(INH_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (fire)                       cnt_q <= '0;
    else if (run && (cnt_q != LAST))     cnt_q <= cnt_q + CW'(1);
  end

  assign expired = run && (cnt_q == LAST);

  // R4: the hold count never runs past its final value while the gate is held
  p_hold_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= LAST));
endmodule

// File: rtl/agate_len_ctr.sv
module agate_len_ctr #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             count_en,
  output logic [LEN_W-1:0] len
);
  localparam logic [LEN_W-1:0] MAXV = {LEN_W{1'b1}};

  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          len_q <= '0;
    else if (start)                      len_q <= LEN_W'(1);
    else if (count_en && len_q != MAXV)  len_q <= len_q + LEN_W'(1);
  end

  assign len = len_q;

  p_len_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !count_en) |=> $stable(len_q));

  p_len_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && len_q == MAXV) |=> (len_q == MAXV));
endmodule

// File: rtl/agate_ctrl.sv
module agate_ctrl #(
  parameter int INH_CYC = 110,
  parameter int LEN_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rearm,
  input  logic             auto_en,
  input  logic             decade_pulse,
  output logic             gate_open,
  output logic             meas_done,
  output logic [LEN_W-1:0] gate_len
);
  import agate_pkg::*;

  agate_st_t st_q, st_d;
  logic      open_evt, close_evt, hold_over, done_q;

  assign open_evt  = !rearm && auto_en && decade_pulse && (st_q == ST_READY);
  assign close_evt = !rearm && decade_pulse &&
                     ((st_q == ST_ARMED) || (st_q == ST_HOLD && hold_over));

  always_comb begin
    st_d = st_q;
    if (rearm) begin
      st_d = ST_READY;
    end else begin
      unique case (st_q)
        ST_READY: if (open_evt)       st_d = ST_HOLD;
        ST_HOLD:  if (close_evt)      st_d = ST_SPENT;
                  else if (hold_over) st_d = ST_ARMED;
        ST_ARMED: if (close_evt)      st_d = ST_SPENT;
        ST_SPENT: st_d = ST_SPENT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_READY;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= close_evt;
    end
  end

  agate_oneshot #(.INH_CYC(INH_CYC)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (open_evt),
    .run     (st_q == ST_HOLD),
    .expired (hold_over)
  );

  agate_len_ctr #(.LEN_W(LEN_W)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (open_evt),
    .count_en (gate_open && !close_evt && !rearm),
    .len      (gate_len)
  );

  assign gate_open = (st_q == ST_HOLD) || (st_q == ST_ARMED);
  assign meas_done = done_q;

  p_rearm_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> (!gate_open && !meas_done));

  p_hold_keeps_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && !hold_over && !rearm) |=> gate_open);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |=> !meas_done);

  p_done_after_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |-> (!gate_open && $past(gate_open)));

  p_spent_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SPENT && !rearm) |=> !gate_open);
endmodule

// File: tb/tb_agate_ctrl.sv
module tb_agate_ctrl;
  localparam int INH = 110;
  localparam int LW  = 12;

  logic clk = 1'b0, rst_n = 1'b0, rearm = 1'b0, auto_en = 1'b1, decade = 1'b0;
  logic gate_open, meas_done;
  logic [LW-1:0] gate_len;
  int checks = 0, fails = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  agate_ctrl #(.INH_CYC(INH), .LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .rearm(rearm), .auto_en(auto_en),
    .decade_pulse(decade), .gate_open(gate_open), .meas_done(meas_done),
    .gate_len(gate_len)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    decade = 1'b1;
    @(negedge clk);
    decade = 1'b0;
  endtask

  task automatic do_rearm();
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
    @(negedge clk);
  endtask

  // Opens a gate, optionally sends an early pulse at offset e, closes at offset d.
  task automatic run_meas(input int e, input int d, input int exp_len, input string tag);
    do_rearm();
    pulse();
    chk({tag, " R3 open"}, gate_open, 1);
    if (e > 0) begin
      idle(e - 1);
      pulse();
      chk({tag, " R4 early ignored gate"}, gate_open, 1);
      chk({tag, " R4 early no done"}, meas_done, 0);
      idle(d - e - 1);
    end else begin
      idle(d - 1);
    end
    pulse();
    chk({tag, " R5 closed"}, gate_open, 0);
    chk({tag, " R6 done high"}, meas_done, 1);
    chk({tag, " R7 length"}, int'(gate_len), exp_len);
    idle(1);
    chk({tag, " R6 done single"}, meas_done, 0);
    idle(5);
    chk({tag, " R7 length held"}, int'(gate_len), exp_len);
  endtask

  task automatic t_reset();
    idle(1);
    chk("R1 gate", gate_open, 0);
    chk("R1 done", meas_done, 0);
    chk("R1 len", int'(gate_len), 0);
  endtask

  task automatic t_auto_off();
    do_rearm();
    auto_en = 1'b0;
    pulse();
    chk("R3 auto off no open", gate_open, 0);
    auto_en = 1'b1;
  endtask

  task automatic t_rearm_blocks();
    rearm = 1'b1;
    pulse();
    chk("R2 start ignored under rearm", gate_open, 0);
    rearm = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_abort();
    do_rearm();
    pulse();
    idle(40);
    rearm = 1'b1;
    decade = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
    decade = 1'b0;
    chk("R2 abort closes", gate_open, 0);
    chk("R2 abort no done", meas_done, 0);
    idle(1);
    chk("R2 abort no done later", meas_done, 0);
  endtask

  task automatic t_spent();
    run_meas(0, 130, 130, "spent");
    pulse();
    chk("R9 no reopen", gate_open, 0);
    idle(3);
    pulse();
    chk("R9 still closed", gate_open, 0);
    do_rearm();
    pulse();
    chk("R9 reopen after rearm", gate_open, 1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_auto_off();
    t_rearm_blocks();
    run_meas(25, 250, 250, "example");
    run_meas(INH - 1, INH, INH, "boundary");
    run_meas(0, 700, 700, "plain");
    t_abort();
    t_spent();
    run_meas(0, 5000, 4095, "R8 saturate");
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule